// File: doc/BRIEF.md
# Nested Priority Event Controller

This block sits beside a processor core and decides which of sixteen event levels the core should service next. Level 0 ranks highest and level 15 lowest. Each level has a pending latch that captures its request input. A mask register gates the maskable levels. A service register records every level whose handler has been entered and not yet left. The controller offers a vector (a request flag plus the level index) only when the best eligible pending level outranks every level already in service. A handler can therefore be preempted by a more urgent event, but never by an equal or lower one.

The core acknowledges an offered vector with a one-cycle strobe. That moves the level from pending to in-service. When a handler finishes, the core pulses a return strobe, which retires the innermost (highest-priority) active level. A small register port lets software read the three registers, clear pending bits by writing ones, and program the mask.

Bit 4 of the mask register is a global enable. Level 4 is not an event source. Levels 0 to 3 always bypass the mask.

Top module: `evt_nest_ctrl`

## Requirements
- R1: After reset the pending, mask and in-service registers all read zero and `vec_req_o` is low.
- R2: A high `evt_req_i[n]` at a clock edge sets pending bit n. The bit then stays set until that level is accepted or software clears it. This holds even while the level is masked.
- R3: A write with `reg_sel_i`=0 clears every pending bit written as 1 and leaves bits written as 0 unchanged. A request input that is high in the same cycle keeps its bit set.
- R4: With `reg_sel_i`=1 a write stores mask bits 15..4. Bits 3..0 are not stored and read as 0. Mask bit n (n>=5) enables level n, and the reset value 0 blocks every maskable level.
- R5: Levels 0 to 3 are offered whenever they are pending, whatever the mask and global enable hold.
- R6: While mask bit 4 (global enable) is 0, no level from 5 to 15 is offered, even if its own mask bit is 1.
- R7: `vec_idx_o` is the lowest-numbered eligible pending level. `vec_req_o` is high only when that level number is strictly below every in-service level, so an equal or lower level never preempts.
- R8: `vec_ack_i` high while `vec_req_o` is high sets in-service bit `vec_idx_o` and clears its pending bit at that edge, unless its request input is still high. `vec_ack_i` high while `vec_req_o` is low changes nothing.
- R9: `ret_i` clears the lowest-numbered set in-service bit. With no bit set it has no effect.
- R10: The level-4 request input is ignored: pending bit 4 never sets and level 4 is never offered.
- R11: Reads return pending for `reg_sel_i`=0, mask for 1, in-service for 2 and zero for 3. Writes with `reg_sel_i`=2 or 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_req_i | input | 16 | Request input per level |
| reg_sel_i | input | 2 | Register select: 0 pending, 1 mask, 2 in-service, 3 none |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for the selected register (combinational) |
| vec_req_o | output | 1 | A level is offered to the core |
| vec_idx_o | output | 4 | Index of the offered level |
| vec_ack_i | input | 1 | Core accepts the offered level |
| ret_i | input | 1 | Return strobe: retire the innermost active level |

## Verification
The checker watches six properties on every cycle:

- the offered level outranks all in-service levels and is itself pending;
- no maskable level is offered with the global enable clear;
- level 4 never becomes pending or active;
- pending bits set on requests and drop only through a clear write or an accept;
- an accept lands in the in-service register;
- a return removes exactly one active level.

Some behaviour can only be shown by the directed scenarios. These cover which level is chosen among several pending ones, and a nested preempt followed by unwinding in the right order. They also cover requests that win over a clear in the same cycle, the register read map, and the cases where an acknowledge or return arrives with nothing to act on.

// File: rtl/evt_nest_pkg.sv
package evt_nest_pkg;
  // Register port selector encoding
  typedef enum logic [1:0] {
    RSEL_PEND = 2'd0,
    RSEL_MASK = 2'd1,
    RSEL_SVC  = 2'd2,
    RSEL_NONE = 2'd3
  } rsel_e;
endpackage

// File: rtl/evt_pend_latch.sv
module evt_pend_latch #(
  parameter int NUM_LVL = 16,
  parameter int GEN_BIT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LVL-1:0] req_i,
  input  logic [NUM_LVL-1:0] w1c_i,
  input  logic [NUM_LVL-1:0] take_i,
  output logic [NUM_LVL-1:0] pend_o
);
  // Level GEN_BIT is the global enable, never a source (R10)
  localparam logic [NUM_LVL-1:0] SRC_VALID = ~(NUM_LVL'(1) << GEN_BIT);

  function automatic logic [NUM_LVL-1:0] next_pend(
    input logic [NUM_LVL-1:0] cur, input logic [NUM_LVL-1:0] req,
    input logic [NUM_LVL-1:0] clr, input logic [NUM_LVL-1:0] take);
    // a request in the same cycle wins over both clears (R3, R8)
    next_pend = (cur & ~clr & ~take) | (req & SRC_VALID);
  endfunction

  logic [NUM_LVL-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= next_pend(pend_q, req_i, w1c_i, take_i);
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/evt_prio_sel.sv
module evt_prio_sel #(
  parameter int NUM_LVL    = 16,
  parameter int UNMASK_CNT = 4,
  parameter int GEN_BIT    = 4,
  localparam int IDX_W     = $clog2(NUM_LVL)
) (
  input  logic [NUM_LVL-1:0] pend_i,
  input  logic [NUM_LVL-1:0] mask_i,
  input  logic [NUM_LVL-1:0] svc_i,
  output logic [IDX_W-1:0]   win_idx_o,
  output logic               preempt_o
);
  function automatic logic [IDX_W-1:0] first_idx(input logic [NUM_LVL-1:0] v);
    first_idx = '0;
    for (int i = NUM_LVL - 1; i >= 0; i--) begin
      if (v[i]) first_idx = IDX_W'(i);
    end
  endfunction

  logic [NUM_LVL-1:0] elig;
  logic [IDX_W-1:0]   act_idx;
  logic               win_any, act_any, gen_en;
  logic               unused_bits;

  assign gen_en = mask_i[GEN_BIT];

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    if (g == GEN_BIT) begin : g_gen
      assign elig[g] = 1'b0;
    end else if (g < UNMASK_CNT) begin : g_fixed
      assign elig[g] = pend_i[g];
    end else begin : g_mskd
      assign elig[g] = pend_i[g] & mask_i[g] & gen_en;
    end
  end

  assign unused_bits = ^{mask_i[UNMASK_CNT-1:0], pend_i[GEN_BIT]};

  assign win_any   = |elig;
  assign act_any   = |svc_i;
  assign win_idx_o = first_idx(elig);
  assign act_idx   = first_idx(svc_i);
  // strict outranking of every active level (R7)
  assign preempt_o = win_any & (~act_any | (win_idx_o < act_idx));
endmodule

// File: rtl/evt_svc_track.sv
module evt_svc_track #(
  parameter int NUM_LVL = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LVL-1:0] take_i,
  input  logic               ret_i,
  output logic [NUM_LVL-1:0] svc_o
);
  function automatic logic [NUM_LVL-1:0] lowest_onehot(input logic [NUM_LVL-1:0] v);
    lowest_onehot = v & (~v + NUM_LVL'(1));
  endfunction

  logic [NUM_LVL-1:0] svc_q, retire_vec;

  assign retire_vec = ret_i ? lowest_onehot(svc_q) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) svc_q <= '0;
    else        svc_q <= (svc_q & ~retire_vec) | take_i;
  end

  assign svc_o = svc_q;
endmodule

// File: rtl/evt_nest_ctrl.sv
module evt_nest_ctrl #(
  parameter int NUM_LVL    = 16,
  parameter int UNMASK_CNT = 4,
  parameter int GEN_BIT    = 4,
  localparam int IDX_W     = $clog2(NUM_LVL)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LVL-1:0] evt_req_i,
  input  logic [1:0]         reg_sel_i,
  input  logic               reg_wr_i,
  input  logic [NUM_LVL-1:0] reg_wdata_i,
  output logic [NUM_LVL-1:0] reg_rdata_o,
  output logic               vec_req_o,
  output logic [IDX_W-1:0]   vec_idx_o,
  input  logic               vec_ack_i,
  input  logic               ret_i
);
  import evt_nest_pkg::*;

  localparam logic [NUM_LVL-1:0] MASK_STORE = ~((NUM_LVL'(1) << UNMASK_CNT) - NUM_LVL'(1));

  rsel_e              rsel;
  logic               wr_pend, wr_mask, acc_fire, preempt;
  logic [IDX_W-1:0]   win_idx;
  logic [NUM_LVL-1:0] pend_q, mask_q, svc_q, w1c_vec, take_vec;

  assign rsel     = rsel_e'(reg_sel_i);
  assign wr_pend  = reg_wr_i && (rsel == RSEL_PEND);
  assign wr_mask  = reg_wr_i && (rsel == RSEL_MASK);
  assign w1c_vec  = wr_pend ? reg_wdata_i : '0;
  assign acc_fire = vec_ack_i & preempt;
  assign take_vec = acc_fire ? (NUM_LVL'(1) << win_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (wr_mask) mask_q <= reg_wdata_i & MASK_STORE;
  end

  evt_pend_latch #(.NUM_LVL(NUM_LVL), .GEN_BIT(GEN_BIT)) pend_i (
    .clk(clk), .rst_n(rst_n), .req_i(evt_req_i), .w1c_i(w1c_vec),
    .take_i(take_vec), .pend_o(pend_q));

  evt_prio_sel #(.NUM_LVL(NUM_LVL), .UNMASK_CNT(UNMASK_CNT), .GEN_BIT(GEN_BIT)) sel_i (
    .pend_i(pend_q), .mask_i(mask_q), .svc_i(svc_q),
    .win_idx_o(win_idx), .preempt_o(preempt));

  evt_svc_track #(.NUM_LVL(NUM_LVL)) svc_i (
    .clk(clk), .rst_n(rst_n), .take_i(take_vec), .ret_i(ret_i), .svc_o(svc_q));

  always_comb begin
    unique case (rsel)
      RSEL_PEND: reg_rdata_o = pend_q;
      RSEL_MASK: reg_rdata_o = mask_q;
      RSEL_SVC:  reg_rdata_o = svc_q;
      default:   reg_rdata_o = '0;
    endcase
  end

  assign vec_req_o = preempt;
  assign vec_idx_o = win_idx;
endmodule

// File: rtl/evt_nest_ctrl_chk.sv
module evt_nest_ctrl_chk #(
  parameter int NUM_LVL    = 16,
  parameter int UNMASK_CNT = 4,
  parameter int GEN_BIT    = 4,
  localparam int IDX_W     = $clog2(NUM_LVL)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_LVL-1:0] evt_req_i,
  input logic [1:0]         reg_sel_i,
  input logic               reg_wr_i,
  input logic               vec_req_o,
  input logic [IDX_W-1:0]   vec_idx_o,
  input logic               vec_ack_i,
  input logic               ret_i,
  input logic [NUM_LVL-1:0] pend,
  input logic [NUM_LVL-1:0] mask,
  input logic [NUM_LVL-1:0] svc
);
  localparam logic [NUM_LVL-1:0] SRCS = ~(NUM_LVL'(1) << GEN_BIT);

  function automatic int top_active(input logic [NUM_LVL-1:0] v);
    top_active = NUM_LVL;
    for (int i = 0; i < NUM_LVL; i++) begin
      if (v[i] && top_active == NUM_LVL) top_active = i;
    end
  endfunction

  logic clr_wr, accept;
  assign clr_wr = reg_wr_i && (reg_sel_i == 2'd0);
  assign accept = vec_ack_i && vec_req_o;

  a_r7_outranks_active: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req_o |-> (int'(vec_idx_o) < top_active(svc)));
  a_r7_offer_is_pending: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req_o |-> pend[vec_idx_o]);
  a_r6_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_req_o && !mask[GEN_BIT]) |-> (int'(vec_idx_o) < UNMASK_CNT));
  a_r10_no_gen_source: assert property (@(posedge clk) disable iff (!rst_n)
    !pend[GEN_BIT] && !svc[GEN_BIT]);
  a_r4_low_mask_zero: assert property (@(posedge clk) disable iff (!rst_n)
    mask[UNMASK_CNT-1:0] == '0);
  a_r2_req_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_req_i & SRCS)) |=> ((($past(evt_req_i) & SRCS) & ~pend) == '0));
  a_r2_pend_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_wr && !accept) |=> (($past(pend) & ~pend) == '0));
  a_r8_accept_marks: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> svc[$past(vec_idx_o)]);
  a_r9_return_one: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !accept && (svc != '0)) |=> ($countones(svc) == $countones($past(svc)) - 1));
endmodule

bind evt_nest_ctrl evt_nest_ctrl_chk #(
  .NUM_LVL(NUM_LVL), .UNMASK_CNT(UNMASK_CNT), .GEN_BIT(GEN_BIT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .evt_req_i(evt_req_i), .reg_sel_i(reg_sel_i),
  .reg_wr_i(reg_wr_i), .vec_req_o(vec_req_o), .vec_idx_o(vec_idx_o),
  .vec_ack_i(vec_ack_i), .ret_i(ret_i), .pend(pend_q), .mask(mask_q), .svc(svc_q)
);

// File: tb/evt_nest_ctrl_tb.sv
module evt_nest_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] evt_req = '0;
  logic [1:0]  reg_sel = 2'd3;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        vec_req;
  logic [3:0]  vec_idx;
  logic        vec_ack = 1'b0;
  logic        ret = 1'b0;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  evt_nest_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .evt_req_i(evt_req), .reg_sel_i(reg_sel),
    .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .vec_req_o(vec_req), .vec_idx_o(vec_idx), .vec_ack_i(vec_ack), .ret_i(ret));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_reg(input string tag, input logic [1:0] sel, input logic [15:0] exp);
    reg_sel = sel;
    #1;
    check(tag, 32'(reg_rdata), 32'(exp));
  endtask

  task automatic check_vec(input string tag, input logic req, input logic [3:0] idx);
    check({tag, " req"}, 32'(vec_req), 32'(req));
    if (req) check({tag, " idx"}, 32'(vec_idx), 32'(idx));
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulse(input logic [15:0] lv);
    evt_req = lv; step(); evt_req = '0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1; step(); reg_wr = 1'b0;
  endtask

  task automatic ack();
    vec_ack = 1'b1; step(); vec_ack = 1'b0;
  endtask

  task automatic do_ret();
    ret = 1'b1; step(); ret = 1'b0;
  endtask

  task automatic t_reset();
    check_reg("R1 pending", 2'd0, 16'h0000);
    check_reg("R1 mask", 2'd1, 16'h0000);
    check_reg("R1 in-service", 2'd2, 16'h0000);
    check_vec("R1 vector", 1'b0, 4'd0);
  endtask

  task automatic t_masked_capture();
    pulse(16'h0200);
    check_reg("R2 masked capture", 2'd0, 16'h0200);
    check_vec("R4 masked not offered", 1'b0, 4'd0);
    repeat (3) step();
    check_reg("R2 latch holds", 2'd0, 16'h0200);
  endtask

  task automatic t_level4();
    wr(2'd1, 16'hFFF0);
    pulse(16'h0010);
    check_reg("R10 level4 not latched", 2'd0, 16'h0200);
    check_vec("R10 level4 not offered", 1'b1, 4'd9);
    wr(2'd1, 16'h0000);
  endtask

  task automatic t_unmaskable();
    pulse(16'h0004);
    check_vec("R5 level2 with mask zero", 1'b1, 4'd2);
    ack();
    check_reg("R8 accept sets in-service", 2'd2, 16'h0004);
    check_reg("R8 accept clears pending", 2'd0, 16'h0200);
    do_ret();
    check_reg("R9 return clears", 2'd2, 16'h0000);
  endtask

  task automatic t_global();
    wr(2'd1, 16'h0200);
    check_vec("R6 global enable off", 1'b0, 4'd0);
    wr(2'd1, 16'h021F);
    check_reg("R4 low mask bits dropped", 2'd1, 16'h0210);
    check_vec("R6 global enable on", 1'b1, 4'd9);
  endtask

  task automatic t_nesting();
    wr(2'd1, 16'h02B0);
    pulse(16'h0080);
    check_vec("R7 lowest level wins", 1'b1, 4'd7);
    ack();
    check_reg("R8 level7 active", 2'd2, 16'h0080);
    check_vec("R7 lower level held off", 1'b0, 4'd0);
    pulse(16'h0020);
    check_vec("R7 higher level preempts", 1'b1, 4'd5);
    ack();
    check_reg("R8 nested active", 2'd2, 16'h00A0);
    pulse(16'h0080);
    check_vec("R7 equal level no preempt", 1'b0, 4'd0);
    wr(2'd2, 16'hFFFF);
    check_reg("R11 in-service not writable", 2'd2, 16'h00A0);
    do_ret();
    check_reg("R9 innermost retired", 2'd2, 16'h0080);
    check_vec("R7 still equal level", 1'b0, 4'd0);
    do_ret();
    check_reg("R9 all retired", 2'd2, 16'h0000);
    check_vec("R7 pending resumes", 1'b1, 4'd7);
  endtask

  task automatic t_w1c();
    check_reg("R3 before clear", 2'd0, 16'h0280);
    wr(2'd0, 16'h0080);
    check_reg("R3 selective clear", 2'd0, 16'h0200);
    evt_req = 16'h0200;
    wr(2'd0, 16'h0200);
    evt_req = '0;
    check_reg("R3 request wins over clear", 2'd0, 16'h0200);
    wr(2'd0, 16'hFFFF);
    check_reg("R3 clear all", 2'd0, 16'h0000);
    check_vec("R3 nothing offered", 1'b0, 4'd0);
  endtask

  task automatic t_idle_strobes();
    ack();
    check_reg("R8 stray ack ignored", 2'd2, 16'h0000);
    do_ret();
    check_reg("R9 return on empty", 2'd2, 16'h0000);
    check_reg("R11 select 3 reads zero", 2'd3, 16'h0000);
  endtask

  task automatic t_held_request();
    evt_req = 16'h0001;
    step();
    check_vec("R5 level0 offered", 1'b1, 4'd0);
    ack();
    check_reg("R8 held request keeps pending", 2'd0, 16'h0001);
    evt_req = '0;
    step();
    check_vec("R7 same level no reentry", 1'b0, 4'd0);
    do_ret();
    check_vec("R9 level0 again after return", 1'b1, 4'd0);
    ack();
    check_reg("R8 pending cleared", 2'd0, 16'h0000);
    do_ret();
    check_reg("R9 back to idle", 2'd2, 16'h0000);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_masked_capture();
    t_level4();
    t_unmaskable();
    t_global();
    t_nesting();
    t_w1c();
    t_idle_strobes();
    t_held_request();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule